// File: doc/BRIEF.md
# Byte ALU and Single-Step Shifter Execution Unit

This block is the execute stage of a small 8-bit input/output controller. Each cycle in which `exec_en` is high, it applies one operation to the register operand. The logic and arithmetic operations combine the operand with an immediate byte. The shift and rotate operations move the operand by one bit position. The result, the register write strobe and the flag-update decision are all combinational. The zero condition flag is held in a flop and changes on the clock edge that ends the operation.

Upstream logic decodes the instruction word and presents the operand, immediate, operation code and shift-count field. The register file writes `result` back when `reg_we` is high. Branch logic reads `zero_flag`. A compare updates only the flag. Shifts and rotates write the register and leave the flag as it was, so a branch can still test the flag from an earlier compare.

Top module: `exu_alu_shift`

## Requirements
- R1: With `exec_en` high, op 0 (XOR), op 1 (OR) and op 2 (AND) drive `result` to the bitwise combination of `reg_val` and `imm_val`, with `reg_we` = 1 in the same cycle.
- R2: With `exec_en` high, op 3 (ADD) drives `result` = (`reg_val` + `imm_val`) mod 256 with `reg_we` = 1; there is no carry output.
- R3: With `exec_en` high, op 4 (compare) keeps `reg_we` = 0, and after the next clock edge `zero_flag` is 1 exactly when `reg_val` equals `imm_val`.
- R4: After an op 0 to 3 with `exec_en` high, `zero_flag` is 1 after the next clock edge exactly when the 8-bit result was zero, and 0 otherwise.
- R5: With `exec_en` high and `reg_we` = 1, the shifts give these results. Op 8 (logical left) and op 10 (arithmetic left) shift left by one with 0 entering bit 0. Op 9 (logical right) shifts right by one with 0 entering bit 7. Op 11 (arithmetic right) shifts right by one with a constant 1 entering bit 7.
- R6: With `exec_en` high and `reg_we` = 1, op 12 (rotate left) moves bit 7 into bit 0, and op 13 (rotate right) moves bit 0 into bit 7.
- R7: Ops 8 to 13 leave `zero_flag` unchanged across the clock edge.
- R8: The 3-bit `shift_cnt` input has no effect: every shift and rotate moves by exactly one position.
- R9: While `exec_en` is low, `reg_we` is 0 and `zero_flag` holds its value.
- R10: Op codes 5, 6, 7, 14 and 15 are reserved. They drive `result` = `reg_val` and `reg_we` = 0, and they leave `zero_flag` unchanged.
- R11: A clock edge with `rst` high (synchronous, active high) clears `zero_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Operation issued this cycle |
| op_sel | input | 4 | Operation code |
| reg_val | input | 8 | Register operand |
| imm_val | input | 8 | Immediate operand |
| shift_cnt | input | 3 | Shift-count field, ignored |
| result | output | 8 | Operation result |
| reg_we | output | 1 | Register write-back strobe |
| zero_flag | output | 1 | Registered zero condition flag |

## Verification
The bench builds the unit with its defaults: an 8-bit datapath, a 4-bit operation code and a 3-bit count field. At these widths every op code, including the five reserved ones, is reachable. Every count value is reachable too, which is what shows that the count is ignored. The random stimulus draws operands and immediates from a narrow pool part of the time. This makes equal operands, zero results and ADD wrap-around occur often, so both flag polarities are exercised. Directed cases cover all-ones, all-zeros and single-bit operands, so each shift fill and each rotate carry-in is seen at both ends of the byte.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_XOR = 4'd0,
        OP_OR  = 4'd1,
        OP_AND = 4'd2,
        OP_ADD = 4'd3,
        OP_CMP = 4'd4,
        OP_SLL = 4'd8,
        OP_SLR = 4'd9,
        OP_SAL = 4'd10,
        OP_SAR = 4'd11,
        OP_ROL = 4'd12,
        OP_ROR = 4'd13
    } exu_op_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_CMP   = 2'd2,
        CLS_SHIFT = 2'd3
    } exu_cls_e;

    function automatic exu_cls_e classify(input logic [OP_W-1:0] op);
        case (op)
            OP_XOR, OP_OR, OP_AND, OP_ADD:                  classify = CLS_LOGIC;
            OP_CMP:                                         classify = CLS_CMP;
            OP_SLL, OP_SLR, OP_SAL, OP_SAR, OP_ROL, OP_ROR: classify = CLS_SHIFT;
            default:                                        classify = CLS_NONE;
        endcase
    endfunction
endpackage

// File: rtl/exu_logic.sv
module exu_logic
    import exu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output logic              res_zero
);
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] diff_w;

    assign sum_w  = opa + opb;
    assign diff_w = opa - opb;

    always_comb begin
        case (op)
            OP_XOR:  res = opa ^ opb;
            OP_OR:   res = opa | opb;
            OP_AND:  res = opa & opb;
            OP_ADD:  res = sum_w;
            OP_CMP:  res = diff_w;
            default: res = opa;
        endcase
    end

    assign res_zero = (res == '0);
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
    import exu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] res
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] left_w;
    logic [DATA_W-1:0] right_w;
    logic              left_in;
    logic              right_in;

    always_comb begin
        case (op)
            OP_ROL:  left_in = opa[MSB];
            default: left_in = 1'b0;
        endcase
        case (op)
            OP_SAR:  right_in = 1'b1;
            OP_ROR:  right_in = opa[0];
            default: right_in = 1'b0;
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bits
        if (i == 0) begin : g_lo
            assign left_w[i]  = left_in;
            assign right_w[i] = opa[i+1];
        end else if (i == MSB) begin : g_hi
            assign left_w[i]  = opa[i-1];
            assign right_w[i] = right_in;
        end else begin : g_mid
            assign left_w[i]  = opa[i-1];
            assign right_w[i] = opa[i+1];
        end
    end

    always_comb begin
        case (op)
            OP_SLL, OP_SAL, OP_ROL: res = left_w;
            OP_SLR, OP_SAR, OP_ROR: res = right_w;
            default:                res = opa;
        endcase
    end
endmodule

// File: rtl/exu_zflag.sv
module exu_zflag (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic zero_in,
    output logic zero_q
);
    typedef struct packed {
        logic z;
    } zst_t;

    zst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd) st_d.z = zero_in;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign zero_q = st_q.z;

    // R11: a reset edge clears the flag
    p_reset_clear_r11: assert property (@(posedge clk) rst |=> !zero_q)
        else $error("zero flag not cleared by reset");

    // R4: a requested update loads the supplied value
    p_update_load_r4: assert property (@(posedge clk) disable iff (rst)
        upd |=> (zero_q == $past(zero_in)))
        else $error("zero flag update lost");
endmodule

// File: rtl/exu_alu_shift.sv
module exu_alu_shift
    import exu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] imm_val,
    input  logic [CNT_W-1:0]  shift_cnt,
    output logic [DATA_W-1:0] result,
    output logic              reg_we,
    output logic              zero_flag
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        logic              upd;
        logic              zero;
    } exu_out_t;

    logic [DATA_W-1:0] logic_res;
    logic              logic_zero;
    logic [DATA_W-1:0] shift_res;
    exu_cls_e          cls;
    exu_out_t          out_d;
    logic              unused_cnt;

    assign unused_cnt = ^shift_cnt;
    assign cls        = classify(op_sel);

    exu_logic #(.DATA_W(DATA_W)) u_logic (
        .op       (op_sel),
        .opa      (reg_val),
        .opb      (imm_val),
        .res      (logic_res),
        .res_zero (logic_zero)
    );

    exu_shifter #(.DATA_W(DATA_W)) u_shift (
        .op  (op_sel),
        .opa (reg_val),
        .res (shift_res)
    );

    always_comb begin
        out_d      = '0;
        out_d.res  = reg_val;
        out_d.zero = logic_zero;
        case (cls)
            CLS_LOGIC: begin
                out_d.res = logic_res;
                out_d.we  = exec_en;
                out_d.upd = exec_en;
            end
            CLS_CMP: begin
                out_d.res = logic_res;
                out_d.upd = exec_en;
            end
            CLS_SHIFT: begin
                out_d.res = shift_res;
                out_d.we  = exec_en;
            end
            default: ;
        endcase
    end

    exu_zflag u_zflag (
        .clk     (clk),
        .rst     (rst),
        .upd     (out_d.upd),
        .zero_in (out_d.zero),
        .zero_q  (zero_flag)
    );

    assign result = out_d.res;
    assign reg_we = out_d.we;

    // R3: compare never writes the register
    p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_CMP) |-> !reg_we)
        else $error("compare raised write strobe");

    // R3: compare of equal operands sets the flag
    p_cmp_equal_r3: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_sel == OP_CMP && reg_val == imm_val) |=> zero_flag)
        else $error("equal compare did not set flag");

    // R7: shifts and rotates keep the flag
    p_shift_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_sel >= 4'd8 && op_sel <= 4'd13) |=> $stable(zero_flag))
        else $error("shift disturbed zero flag");

    // R9: idle cycles neither write nor move the flag
    p_idle_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        !exec_en |-> !reg_we)
        else $error("write strobe while idle");

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(zero_flag))
        else $error("flag moved while idle");
endmodule

// File: tb/test_exu_alu_shift.sv
module test_exu_alu_shift;
    logic       clk = 1'b0;
    logic       rst;
    logic       exec_en;
    logic [3:0] op_sel;
    logic [7:0] reg_val;
    logic [7:0] imm_val;
    logic [2:0] shift_cnt;
    logic [7:0] result;
    logic       reg_we;
    logic       zero_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    bit model_z;

    always #5 clk = ~clk;

    exu_alu_shift i_exu_alu_shift (
        .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
        .reg_val(reg_val), .imm_val(imm_val), .shift_cnt(shift_cnt),
        .result(result), .reg_we(reg_we), .zero_flag(zero_flag)
    );

    function automatic logic [7:0] ref_res(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            4'd0:  return a ^ b;                 // R1
            4'd1:  return a | b;                 // R1
            4'd2:  return a & b;                 // R1
            4'd3:  return 8'(a + b);             // R2
            4'd4:  return 8'(a - b);             // R3
            4'd8, 4'd10: return {a[6:0], 1'b0};  // R5
            4'd9:  return {1'b0, a[7:1]};        // R5
            4'd11: return {1'b1, a[7:1]};        // R5
            4'd12: return {a[6:0], a[7]};        // R6
            4'd13: return {a[0], a[7:1]};        // R6
            default: return a;                   // R10
        endcase
    endfunction

    function automatic bit ref_we(input logic [3:0] op);
        return (op <= 4'd3) || (op >= 4'd8 && op <= 4'd13);
    endfunction

    function automatic bit ref_upd(input logic [3:0] op);
        return op <= 4'd4;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        if (op <= 4'd2) return "R1";
        if (op == 4'd3) return "R2";
        if (op == 4'd4) return "R3";
        if (op == 4'd12 || op == 4'd13) return "R6";
        if (op >= 4'd8 && op <= 4'd11) return "R5";
        return "R10";
    endfunction

    // Drive at negedge, check combinational outputs, then the flag after the edge.
    task automatic run_op(input bit en, input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [2:0] cnt);
        logic [7:0] er;
        @(negedge clk);
        exec_en = en; op_sel = op; reg_val = a; imm_val = b; shift_cnt = cnt;
        #1;
        er = ref_res(op, a, b);
        if (op != 4'd4) check(req_of(op), result, er);
        if (en) check(req_of(op), reg_we, ref_we(op));
        else    check("R9", reg_we, 0);
        if (en && ref_upd(op)) model_z = (er == 8'h00);
        @(posedge clk); #1;
        if (!en)                              check("R9", zero_flag, model_z);
        else if (op == 4'd4)                  check("R3", zero_flag, model_z);
        else if (ref_upd(op))                 check("R4", zero_flag, model_z);
        else if (op >= 4'd8 && op <= 4'd13)   check("R7", zero_flag, model_z);
        else                                  check("R10", zero_flag, model_z);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1; exec_en = 0; op_sel = 0; reg_val = 0; imm_val = 0; shift_cnt = 0;
        repeat (2) @(posedge clk);
        #1 check("R11", zero_flag, 0);
        @(negedge clk) rst = 0;
        model_z = 0;

        // directed corners
        run_op(1, 4'd4, 8'h5A, 8'h5A, 3'd0);   // R3 equal sets flag
        run_op(1, 4'd9, 8'h01, 8'h00, 3'd0);   // R7 zero result, flag stays 1
        run_op(1, 4'd4, 8'h5A, 8'h5B, 3'd0);   // R3 unequal clears
        run_op(1, 4'd3, 8'hFF, 8'h01, 3'd0);   // R2 wrap to zero, R4 set
        run_op(0, 4'd0, 8'h12, 8'h34, 3'd0);   // R9 idle hold
        run_op(1, 4'd11, 8'h00, 8'h00, 3'd5);  // R5 SAR fills 1, R8
        run_op(1, 4'd9, 8'hFF, 8'h00, 3'd7);   // R5 SLR fills 0, R8
        run_op(1, 4'd8, 8'hFF, 8'h00, 3'd3);   // R5
        run_op(1, 4'd10, 8'h81, 8'h00, 3'd6);  // R5
        run_op(1, 4'd12, 8'h80, 8'h00, 3'd2);  // R6
        run_op(1, 4'd13, 8'h01, 8'h00, 3'd4);  // R6
        run_op(1, 4'd2, 8'hF0, 8'h0F, 3'd0);   // R1 AND zero
        run_op(1, 4'd7, 8'h00, 8'h00, 3'd0);   // R10 reserved
        run_op(1, 4'd1, 8'h00, 8'h01, 3'd0);   // R1 OR nonzero
        run_op(1, 4'd15, 8'h00, 8'h00, 3'd0);  // R10 reserved keeps flag 0

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = 8'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                a = 8'($urandom_range(0, 3));
                b = ($urandom_range(0, 1) == 0) ? a : 8'(-a);
            end
            run_op(($urandom_range(0, 7) != 0), 4'($urandom), a, b, 3'($urandom));
        end

        // R11 reset after flag set
        run_op(1, 4'd4, 8'h33, 8'h33, 3'd0);
        @(negedge clk) rst = 1; exec_en = 0;
        @(posedge clk); #1;
        check("R11", zero_flag, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule